// File: doc/BRIEF.md
# Doorbell-Gated Sequence Starter

This block decides, cycle by cycle, whether the command at the head of an execution queue may be dispatched. Software groups commands into sequences. Each sequence opens with a bus-acquire command and closes with a bus-release command. Software announces finished sequences by writing a signed increment to a credit counter, the doorbell. One write can post several sequences at once.

A bus-acquire at the head is dispatched only while the credit count is strictly positive. Dispatching it consumes one credit. If the count is zero or negative, the acquire stays at the head and the stall output is raised until a nonzero doorbell write makes the count positive. Every other command dispatches without touching the count.

An execute-disable input lets the commands already queued at the moment it is raised drain, and holds everything queued after that. An idle output reports that no sequence is open and the queue is empty. The queue storage itself sits outside the block: the block sees only the queue level and the head opcode, and it returns a pop strobe.

Top module: `dbs_seq_starter`

## Requirements
- R1: After reset the count is 0, no command is dispatched and, with an empty queue, the idle output is 1.
- R2: A doorbell write adds its value, taken as 8-bit two's complement, to the count, and the result wraps modulo 256. The count is visible on `db_cnt_o` one cycle after the write. A write of 0 leaves the count unchanged.
- R3: Dispatching an acquire (opcode 4'hA) lowers the count by one. A doorbell write in the same cycle is combined with it into a single update (count + increment − 1).
- R4: When the head is an acquire and the count is zero or negative, the acquire is not dispatched and `acq_stall_o` is 1. The acquire stays blocked, even across zero-valued writes, until the count becomes positive.
- R5: A release (opcode 4'hB) or any other opcode dispatches without regard to the count and leaves the count unchanged.
- R6: While `ex_dis_i` is 1, only the commands present in the queue in the cycle it rose are dispatched. Commands queued afterwards are held.
- R7: When `ex_dis_i` returns to 0, dispatch resumes if the queue is non-empty.
- R8: `idle_o` is 1 exactly when no sequence is open (no acquire dispatched without a later release) and the queue level is 0. `seq_act_o` shows the open state.
- R9: No command is dispatched when the queue level is 0 or `exe_rdy_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| db_wr_i | input | 1 | Doorbell write strobe |
| db_inc_i | input | CNT_W | Signed increment to add to the count |
| db_cnt_o | output | CNT_W | Current two's-complement credit count |
| q_lvl_i | input | LVL_W | Number of commands in the queue |
| head_op_i | input | 4 | Opcode at the queue head |
| exe_rdy_i | input | 1 | Executor can take a command this cycle |
| ex_dis_i | input | 1 | Execute-disable |
| cmd_pop_o | output | 1 | Head command dispatched this cycle |
| acq_stall_o | output | 1 | Head acquire blocked for lack of credit |
| seq_act_o | output | 1 | A sequence is open |
| idle_o | output | 1 | No open sequence and queue empty |

## Verification
The bench builds the block with CNT_W=8 and DEPTH=8. The 8-bit count can then be driven across the +127 to −128 boundary with a single large write. The 8-entry queue makes a full queue and a 4-bit level reachable within a short random run. Directed phases cover the following cases:
- a stall held across zero-valued writes;
- a doorbell write that lands in the same cycle as an acquire;
- an execute-disable drain that overlaps fresh pushes.

A seeded random phase then mixes opcodes, signed writes, executor back-pressure and execute-disable toggles.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  localparam int OP_W = 4;
  localparam logic [OP_W-1:0] OP_ACQ = 4'hA;
  localparam logic [OP_W-1:0] OP_REL = 4'hB;
endpackage

// File: rtl/dbs_credit_ctr.sv
module dbs_credit_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             add_en_i,
  input  logic [CNT_W-1:0] add_val_i,
  input  logic             take_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             credit_ok_o
);
  logic [CNT_W-1:0] cnt_q, inc, dec;

  assign inc = add_en_i ? add_val_i : '0;
  assign dec = {{(CNT_W-1){1'b0}}, take_i};

  // add and take merge into one modular update
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + inc - dec;
  end

  assign cnt_o       = cnt_q;
  assign credit_ok_o = !cnt_q[CNT_W-1] && (cnt_q != '0);
endmodule

// File: rtl/dbs_drain.sv
module dbs_drain #(
  parameter int LVL_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             xd_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic             pop_i,
  output logic             allow_o
);
  logic             xd_q;
  logic [LVL_W-1:0] bud_q;
  logic             rise;

  assign rise    = xd_i && !xd_q;
  assign allow_o = !xd_i || rise || (bud_q != '0);

  // snapshot of entries present when disable rose; later pushes not counted
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xd_q  <= 1'b0;
      bud_q <= '0;
    end else begin
      xd_q <= xd_i;
      if (rise)                              bud_q <= lvl_i - LVL_W'(pop_i);
      else if (xd_i && pop_i && bud_q != '0) bud_q <= bud_q - 1'b1;
    end
  end
endmodule

// File: rtl/dbs_gate.sv
module dbs_gate
  import dbs_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            lvl_nz_i,
  input  logic [OP_W-1:0] head_op_i,
  input  logic            rdy_i,
  input  logic            allow_i,
  input  logic            credit_ok_i,
  output logic            pop_o,
  output logic            take_o,
  output logic            stall_o,
  output logic            seq_act_o
);
  logic is_acq, is_rel, eligible, blocked, seq_q;

  assign is_acq   = head_op_i == OP_ACQ;
  assign is_rel   = head_op_i == OP_REL;
  assign eligible = lvl_nz_i && allow_i;
  assign blocked  = is_acq && !credit_ok_i;
  assign stall_o  = eligible && blocked;
  assign pop_o    = eligible && rdy_i && !blocked;
  assign take_o   = pop_o && is_acq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              seq_q <= 1'b0;
    else if (pop_o && is_acq) seq_q <= 1'b1;
    else if (pop_o && is_rel) seq_q <= 1'b0;
  end

  assign seq_act_o = seq_q;
endmodule

// File: rtl/dbs_seq_starter.sv
module dbs_seq_starter
  import dbs_pkg::*;
#(
  parameter  int CNT_W = 8,
  parameter  int DEPTH = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             db_wr_i,
  input  logic [CNT_W-1:0] db_inc_i,
  output logic [CNT_W-1:0] db_cnt_o,
  input  logic [LVL_W-1:0] q_lvl_i,
  input  logic [OP_W-1:0]  head_op_i,
  input  logic             exe_rdy_i,
  input  logic             ex_dis_i,
  output logic             cmd_pop_o,
  output logic             acq_stall_o,
  output logic             seq_act_o,
  output logic             idle_o
);
  logic credit_ok, allow, take, lvl_nz;

  assign lvl_nz = q_lvl_i != '0;

  dbs_credit_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk_i, .rst_ni,
    .add_en_i   (db_wr_i),
    .add_val_i  (db_inc_i),
    .take_i     (take),
    .cnt_o      (db_cnt_o),
    .credit_ok_o(credit_ok)
  );

  dbs_drain #(.LVL_W(LVL_W)) u_drain (
    .clk_i, .rst_ni,
    .xd_i   (ex_dis_i),
    .lvl_i  (q_lvl_i),
    .pop_i  (cmd_pop_o),
    .allow_o(allow)
  );

  dbs_gate u_gate (
    .clk_i, .rst_ni,
    .lvl_nz_i   (lvl_nz),
    .head_op_i  (head_op_i),
    .rdy_i      (exe_rdy_i),
    .allow_i    (allow),
    .credit_ok_i(credit_ok),
    .pop_o      (cmd_pop_o),
    .take_o     (take),
    .stall_o    (acq_stall_o),
    .seq_act_o  (seq_act_o)
  );

  assign idle_o = !seq_act_o && !lvl_nz;
endmodule

// File: rtl/dbs_seq_starter_chk.sv
module dbs_seq_starter_chk
  import dbs_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int LVL_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             db_wr_i,
  input logic [CNT_W-1:0] db_inc_i,
  input logic [CNT_W-1:0] db_cnt_o,
  input logic [LVL_W-1:0] q_lvl_i,
  input logic [OP_W-1:0]  head_op_i,
  input logic             exe_rdy_i,
  input logic             cmd_pop_o,
  input logic             acq_stall_o,
  input logic             seq_act_o,
  input logic             idle_o
);
  a_r3_acq_needs_credit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_pop_o && head_op_i == OP_ACQ) |-> ($signed(db_cnt_o) > 0));

  a_r3_take_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_pop_o && head_op_i == OP_ACQ && !db_wr_i) |=>
      (db_cnt_o == CNT_W'($past(db_cnt_o) - 1'b1)));

  a_r5_other_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_pop_o && head_op_i != OP_ACQ && !db_wr_i) |=> $stable(db_cnt_o));

  a_r2_zero_add: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (db_wr_i && db_inc_i == '0 && !(cmd_pop_o && head_op_i == OP_ACQ)) |=> $stable(db_cnt_o));

  a_r4_stall_no_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acq_stall_o |-> !cmd_pop_o);

  a_r9_no_pop_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_lvl_i == '0 || !exe_rdy_i) |-> !cmd_pop_o);

  a_r8_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> (q_lvl_i == '0 && !seq_act_o));
endmodule

bind dbs_seq_starter dbs_seq_starter_chk #(.CNT_W(CNT_W), .LVL_W(LVL_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .db_wr_i(db_wr_i), .db_inc_i(db_inc_i),
  .db_cnt_o(db_cnt_o), .q_lvl_i(q_lvl_i), .head_op_i(head_op_i),
  .exe_rdy_i(exe_rdy_i), .cmd_pop_o(cmd_pop_o), .acq_stall_o(acq_stall_o),
  .seq_act_o(seq_act_o), .idle_o(idle_o)
);

// File: tb/tb_dbs_seq_starter.sv
module tb_dbs_seq_starter;
  import dbs_pkg::*;
  localparam int CNT_W = 8;
  localparam int DEPTH = 8;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic db_wr_i = 1'b0;
  logic [CNT_W-1:0] db_inc_i = '0;
  logic [CNT_W-1:0] db_cnt_o;
  logic [LVL_W-1:0] q_lvl_i = '0;
  logic [OP_W-1:0]  head_op_i = '0;
  logic exe_rdy_i = 1'b0;
  logic ex_dis_i = 1'b0;
  logic cmd_pop_o, acq_stall_o, seq_act_o, idle_o;

  always #2 clk_i = ~clk_i;

  dbs_seq_starter #(.CNT_W(CNT_W), .DEPTH(DEPTH)) dut (.*);

  // bench model
  logic [OP_W-1:0] qm [DEPTH];
  int rd_p, wr_p, lvl, m_bud;
  logic [CNT_W-1:0] m_cnt;
  bit m_seq, m_xdq;
  // stimulus
  bit d_wr, d_xd, d_rdy, d_push;
  logic [CNT_W-1:0] d_inc;
  logic [OP_W-1:0] d_op;
  string focus;
  int checks, bad;
  bit done;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit has_credit(logic [CNT_W-1:0] c);
    return $signed(c) > 0;
  endfunction

  task automatic cyc();
    bit rise, allow, acq_h, e_pop, e_stall;
    logic [OP_W-1:0] h;
    @(negedge clk_i);
    h = (lvl != 0) ? qm[rd_p] : '0;
    db_wr_i = d_wr; db_inc_i = d_inc; ex_dis_i = d_xd; exe_rdy_i = d_rdy;
    q_lvl_i = LVL_W'(lvl); head_op_i = h;
    #1;
    rise    = d_xd && !m_xdq;
    allow   = !d_xd || rise || (m_bud != 0);
    acq_h   = (lvl != 0) && (h == OP_ACQ);
    e_stall = (lvl != 0) && allow && acq_h && !has_credit(m_cnt);
    e_pop   = (lvl != 0) && allow && d_rdy && !(acq_h && !has_credit(m_cnt));
    chk(focus != "" ? focus : "R2", "count", 32'(db_cnt_o), 32'(m_cnt));
    chk(focus != "" ? focus : "R4", "stall", 32'(acq_stall_o), 32'(e_stall));
    chk(focus != "" ? focus : (d_xd ? "R6" : (acq_h ? "R3" : "R5")), "pop",
        32'(cmd_pop_o), 32'(e_pop));
    chk(focus != "" ? focus : "R8", "idle", 32'(idle_o), 32'(!m_seq && lvl == 0));
    chk(focus != "" ? focus : "R8", "seq", 32'(seq_act_o), 32'(m_seq));
    @(posedge clk_i);
    if (d_wr) m_cnt = m_cnt + d_inc;
    if (e_pop && acq_h) m_cnt = m_cnt - 1'b1;
    if (e_pop && h == OP_ACQ) m_seq = 1'b1;
    else if (e_pop && h == OP_REL) m_seq = 1'b0;
    if (rise) m_bud = lvl - int'(e_pop);
    else if (d_xd && e_pop && m_bud > 0) m_bud--;
    m_xdq = d_xd;
    if (e_pop) begin rd_p = (rd_p + 1) % DEPTH; lvl--; end
    if (d_push && lvl < DEPTH) begin
      qm[wr_p] = d_op; wr_p = (wr_p + 1) % DEPTH; lvl++;
    end
  endtask

  task automatic idle_stim();
    d_wr = 0; d_inc = '0; d_push = 0; d_op = '0;
  endtask

  task automatic push(logic [OP_W-1:0] op);
    d_push = 1; d_op = op; cyc(); d_push = 0;
  endtask

  initial begin : wdog
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd1357));
    rd_p = 0; wr_p = 0; lvl = 0; m_bud = 0; m_cnt = '0; m_seq = 0; m_xdq = 0;
    d_xd = 0; d_rdy = 0; focus = "";
    idle_stim();
    repeat (2) @(negedge clk_i);
    chk("R1", "reset count", 32'(db_cnt_o), 0);
    chk("R1", "reset idle", 32'(idle_o), 1);
    chk("R1", "reset pop", 32'(cmd_pop_o), 0);
    rst_ni = 1'b1;

    // R4: acquire with zero credit stalls, zero write keeps it stalled
    focus = "R9"; d_rdy = 0;
    push(OP_ACQ); push(4'h3); push(OP_REL);
    focus = "R4"; d_rdy = 1;
    cyc(); cyc();
    d_wr = 1; d_inc = 8'h00; cyc(); d_wr = 0; cyc();
    d_wr = 1; d_inc = 8'hFE; cyc(); d_wr = 0; cyc();   // -2: still stalled
    // R3: positive write releases, acquire takes one
    focus = "R3";
    d_wr = 1; d_inc = 8'h04; cyc(); d_wr = 0;
    cyc();
    focus = "R5"; cyc(); cyc(); cyc();

    // R3: write lands with acquire dispatch
    focus = "R9"; d_rdy = 0;
    push(OP_ACQ); push(OP_REL);
    focus = "R3"; d_rdy = 1; d_wr = 1; d_inc = 8'h03; cyc(); d_wr = 0;
    cyc(); cyc();

    // R2: wrap past +127
    focus = "R2";
    d_wr = 1; d_inc = 8'h7F; cyc(); d_wr = 0; cyc();
    d_wr = 1; d_inc = 8'h7E; cyc(); d_wr = 0; cyc(); cyc();
    d_wr = 1; d_inc = 8'h05; cyc(); d_wr = 0; cyc();

    // R6: drain only pre-queued entries while pushing more
    focus = "R9"; d_rdy = 0;
    push(4'h1); push(4'h2); push(4'h3);
    focus = "R6"; d_rdy = 1; d_xd = 1;
    for (int i = 0; i < 4; i++) push(4'h4);
    cyc(); cyc(); cyc();
    // R7: clear resumes
    focus = "R7"; d_xd = 0;
    for (int i = 0; i < 6; i++) cyc();
    focus = "R8"; cyc(); cyc();

    // random phase
    focus = "";
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      d_push = $urandom_range(0, 99) < 55;
      case ($urandom_range(0, 2))
        0: d_op = OP_ACQ;
        1: d_op = OP_REL;
        default: d_op = OP_W'($urandom_range(0, 9));
      endcase
      d_wr  = r < 12;
      d_inc = CNT_W'($urandom_range(0, 6)) - CNT_W'(2);
      d_rdy = $urandom_range(0, 99) < 70;
      if ($urandom_range(0, 99) < 3) d_xd = !d_xd;
      cyc();
    end
    idle_stim(); d_xd = 0; d_rdy = 1;
    d_wr = 1; d_inc = 8'h40; cyc(); d_wr = 0;
    for (int i = 0; i < 20; i++) cyc();

    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule